// File: doc/BRIEF.md
# Configuration Access Port Translator

This block sits on the host side of a configuration fabric and turns 32-bit I/O port accesses into configuration transactions. It has two I/O locations. The selector register at port 0x0CF8 holds an enable bit and a target (bus, device, function, dword register). The data window at port 0x0CFC starts one configuration read or write at that target. The host writes the selector first and then reads or writes the window. Each window access produces exactly one single-data-phase transaction on a simple parallel interface, or none if the enable bit is clear.

On the host side, requests and responses are valid/ready streams. The block holds at most one request at a time. `io_req_ready` is high only while the block is idle. It falls at the edge that accepts a request and rises again in the cycle after the response is consumed. A response stays valid, with its data unchanged, until `io_rsp_ready` is sampled high. Port bits [1:0] are ignored, and `io_req_be` selects the byte lanes.

On the configuration side, a transaction is held on `cfg_valid` until the target answers with `cfg_done` or `cfg_abort`. If the bus number in the selector equals the `local_bus` pin, the cycle is a Type 0 cycle with a one-hot device select. Otherwise it is a Type 1 cycle that carries the full packed target.

Top module: `cfgx_port_xlat`

## Requirements
- R1: A write to port 0x0CF8 updates only the selector bytes whose `io_req_be` bit is set. Reads of 0x0CF8 return enable in bit 31, bus in [23:16], device in [15:11], function in [10:8] and dword register in [7:2]. Bits [30:24] and [1:0] always read 0.
- R2: While the enable bit is 0, a read of the data window returns 0xFFFFFFFF, a write to it is dropped, and no configuration transaction starts.
- R3: Accesses to ports other than the two dwords 0x0CF8 and 0x0CFC start no transaction and leave the selector unchanged. Reads of such ports return 0xFFFFFFFF.
- R4: When the selector bus equals `local_bus`, the cycle is Type 0. `cfg_type1` is 0 and `cfg_addr` = {21'b0, function, register, 2'b00}. Only `cfg_idsel[device]` is set, or no line is set when device >= NUM_DEV.
- R5: When the selector bus differs from `local_bus`, the cycle is Type 1. `cfg_type1` is 1, `cfg_addr` = {8'b0, bus, device, function, register, 2'b01}, and `cfg_idsel` is all zero.
- R6: A window transaction copies the host byte enables to `cfg_be`, the host direction to `cfg_write` (1 = write) and the host write data to `cfg_wdata`.
- R7: A window read that ends with `cfg_done` returns `cfg_rdata`. One that ends with `cfg_abort` returns 0xFFFFFFFF; abort wins if both are high. Every write response carries 0.
- R8: An enabled window access raises `cfg_valid` exactly once. The address stays stable while `cfg_valid` is high. `cfg_valid` falls in the cycle after `cfg_done` or `cfg_abort` is sampled.
- R9: `io_req_ready` is low while a request is in progress or its response is pending. A response held by low `io_rsp_ready` keeps its valid and its data.
- R10: After reset `io_req_ready` is 1, `io_rsp_valid` and `cfg_valid` are 0, and the selector reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_bus | input | 8 | Bus number of the segment behind this port |
| io_req_valid | input | 1 | Host request valid |
| io_req_ready | output | 1 | Block can accept a request |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_port | input | IO_AW | I/O port address (bits [1:0] ignored) |
| io_req_be | input | 4 | Byte lane enables |
| io_req_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | Response valid |
| io_rsp_ready | input | 1 | Host takes the response |
| io_rsp_rdata | output | 32 | Response data |
| cfg_valid | output | 1 | Configuration transaction in progress |
| cfg_addr | output | 32 | Address-phase word |
| cfg_type1 | output | 1 | 1 = Type 1 forwarded cycle |
| cfg_idsel | output | NUM_DEV | One-hot device select for Type 0 |
| cfg_be | output | 4 | Byte enables of the data phase |
| cfg_write | output | 1 | 1 = configuration write |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Target completed the data phase |
| cfg_abort | input | 1 | Master abort, no target answered |
| cfg_rdata | input | 32 | Read data from the target |

## Verification
The bench builds the block with NUM_DEV = 8 and IO_AW = 16. It drives `local_bus` at 0 and then at 5. With 8 select lines, selector device numbers 8 to 31 fall outside the wired lanes, so the Type 0 case with no select line set is reached, as is the top lane 7. Switching `local_bus` turns the same selector from a Type 1 target into a local one. Stalling `io_rsp_ready` during aborted and completed reads exercises the hold rules.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam logic [15:0] PORT_SEL  = 16'h0CF8;
  localparam logic [15:0] PORT_WIN  = 16'h0CFC;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [1:0]  TYPE0_TAG = 2'b00;
  localparam logic [1:0]  TYPE1_TAG = 2'b01;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] reg_dw;
  } cfg_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RSP  = 2'd2
  } seq_state_t;

  function automatic logic [31:0] sel_to_word(input cfg_sel_t s);
    return {s.en, 7'b0, s.bus, s.dev, s.fn, s.reg_dw, 2'b00};
  endfunction

endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output cfg_sel_t    sel
);

  cfg_sel_t sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_en) begin
      if (wr_be[0]) sel_q.reg_dw <= wr_data[7:2];
      if (wr_be[1]) begin
        sel_q.dev <= wr_data[15:11];
        sel_q.fn  <= wr_data[10:8];
      end
      if (wr_be[2]) sel_q.bus <= wr_data[23:16];
      if (wr_be[3]) sel_q.en  <= wr_data[31];
    end
  end

  assign sel = sel_q;

  // R1: lanes not enabled keep their previous contents
  a_r1_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[2]) |=> $stable(sel_q.bus));

endmodule

// File: rtl/cfgx_cycle_gen.sv
module cfgx_cycle_gen
  import cfgx_pkg::*;
#(
  parameter int NUM_DEV = 32
)(
  input  cfg_sel_t           sel,
  input  logic [7:0]         local_bus,
  input  logic               active,
  output logic [31:0]        addr,
  output logic               type1,
  output logic [NUM_DEV-1:0] idsel
);

  logic is_local;
  logic unused_en;

  assign is_local  = (sel.bus == local_bus);
  assign unused_en = sel.en;
  assign type1     = active && !is_local;

  always_comb begin
    if (!active)
      addr = '0;
    else if (is_local)
      addr = {21'b0, sel.fn, sel.reg_dw, TYPE0_TAG};
    else
      addr = {8'b0, sel.bus, sel.dev, sel.fn, sel.reg_dw, TYPE1_TAG};
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_idsel
    assign idsel[i] = active && is_local && (int'(sel.dev) == i);
  end

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        hit_sel,
  input  logic        hit_win,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic [31:0] sel_word,
  input  logic        sel_en,
  output logic        req_ready,
  output logic        sel_wr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        bus_active,
  output logic [3:0]  bus_be,
  output logic        bus_write,
  output logic [31:0] bus_wdata,
  input  logic        bus_done,
  input  logic        bus_abort,
  input  logic [31:0] bus_rdata
);

  seq_state_t  state_q;
  logic [31:0] rdata_q;
  logic [3:0]  be_q;
  logic        write_q;
  logic [31:0] wdata_q;
  logic        accept;
  logic [31:0] local_rdata;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign sel_wr     = accept && req_write && hit_sel;
  assign rsp_valid  = (state_q == ST_RSP);
  assign bus_active = (state_q == ST_BUS);
  assign rsp_rdata  = rdata_q;
  assign bus_be     = be_q;
  assign bus_write  = write_q;
  assign bus_wdata  = wdata_q;

  always_comb begin
    if (req_write)    local_rdata = '0;
    else if (hit_sel) local_rdata = sel_word;
    else              local_rdata = ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (hit_win && sel_en) begin
            state_q <= ST_BUS;
            be_q    <= req_be;
            write_q <= req_write;
            wdata_q <= req_wdata;
          end else begin
            state_q <= ST_RSP;
            rdata_q <= local_rdata;
          end
        end
        ST_BUS: if (bus_done || bus_abort) begin
          state_q <= ST_RSP;
          if (write_q)        rdata_q <= '0;
          else if (bus_abort) rdata_q <= ALL_ONES;
          else                rdata_q <= bus_rdata;
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled response keeps valid and data
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: nothing is accepted while a response waits
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8: data phase attributes stay fixed during the transaction
  a_r8_phase_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_done && !bus_abort) |=>
      (bus_active && $stable(bus_be) && $stable(bus_wdata) && $stable(bus_write)));

endmodule

// File: rtl/cfgx_port_xlat.sv
module cfgx_port_xlat
  import cfgx_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int IO_AW   = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         local_bus,
  input  logic               io_req_valid,
  output logic               io_req_ready,
  input  logic               io_req_write,
  input  logic [IO_AW-1:0]   io_req_port,
  input  logic [3:0]         io_req_be,
  input  logic [31:0]        io_req_wdata,
  output logic               io_rsp_valid,
  input  logic               io_rsp_ready,
  output logic [31:0]        io_rsp_rdata,
  output logic               cfg_valid,
  output logic [31:0]        cfg_addr,
  output logic               cfg_type1,
  output logic [NUM_DEV-1:0] cfg_idsel,
  output logic [3:0]         cfg_be,
  output logic               cfg_write,
  output logic [31:0]        cfg_wdata,
  input  logic               cfg_done,
  input  logic               cfg_abort,
  input  logic [31:0]        cfg_rdata
);

  localparam logic [IO_AW-1:0] SEL_P = IO_AW'(PORT_SEL);
  localparam logic [IO_AW-1:0] WIN_P = IO_AW'(PORT_WIN);

  cfg_sel_t sel;
  logic     hit_sel, hit_win, sel_wr;
  logic     unused_port_lsb;

  assign hit_sel         = (io_req_port[IO_AW-1:2] == SEL_P[IO_AW-1:2]);
  assign hit_win         = (io_req_port[IO_AW-1:2] == WIN_P[IO_AW-1:2]);
  assign unused_port_lsb = ^io_req_port[1:0];

  cfgx_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr),
    .wr_be   (io_req_be),
    .wr_data (io_req_wdata),
    .sel     (sel)
  );

  cfgx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (io_req_valid),
    .req_write  (io_req_write),
    .hit_sel    (hit_sel),
    .hit_win    (hit_win),
    .req_be     (io_req_be),
    .req_wdata  (io_req_wdata),
    .sel_word   (sel_to_word(sel)),
    .sel_en     (sel.en),
    .req_ready  (io_req_ready),
    .sel_wr     (sel_wr),
    .rsp_valid  (io_rsp_valid),
    .rsp_ready  (io_rsp_ready),
    .rsp_rdata  (io_rsp_rdata),
    .bus_active (cfg_valid),
    .bus_be     (cfg_be),
    .bus_write  (cfg_write),
    .bus_wdata  (cfg_wdata),
    .bus_done   (cfg_done),
    .bus_abort  (cfg_abort),
    .bus_rdata  (cfg_rdata)
  );

  cfgx_cycle_gen #(.NUM_DEV(NUM_DEV)) u_gen (
    .sel       (sel),
    .local_bus (local_bus),
    .active    (cfg_valid),
    .addr      (cfg_addr),
    .type1     (cfg_type1),
    .idsel     (cfg_idsel)
  );

  // R2: a transaction only starts with the enable bit set
  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> sel.en);

  // R8: address phase word is held until completion
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_done && !cfg_abort) |=> (cfg_valid && $stable(cfg_addr)));

  // R4: at most one device select line
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_idsel));

  // R8: the transaction ends after a completion is sampled
  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && (cfg_done || cfg_abort)) |=> !cfg_valid);

  // R3: foreign ports never start a transaction
  a_r3_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && io_req_ready && !hit_win) |=> !cfg_valid);

endmodule

// File: tb/tb_cfgx_port_xlat.sv
module tb_cfgx_port_xlat;

  localparam int ND = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] local_bus = 0;
  logic io_req_valid = 0, io_req_write = 0;
  logic [15:0] io_req_port = 0;
  logic [3:0] io_req_be = 0;
  logic [31:0] io_req_wdata = 0;
  logic io_req_ready, io_rsp_valid;
  logic io_rsp_ready = 1;
  logic [31:0] io_rsp_rdata;
  logic cfg_valid, cfg_type1, cfg_write;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [ND-1:0] cfg_idsel;
  logic [3:0] cfg_be;
  logic cfg_done = 0, cfg_abort = 0;
  logic [31:0] cfg_rdata = 0;

  int checks = 0, errors = 0, txn_count = 0, cyc = 0;
  bit stall_en = 0;

  logic [31:0] rsp_exp_q[$];
  string       rsp_tag_q[$];
  logic [77:0] bus_exp_q[$];
  logic [32:0] bus_rep_q[$];
  string       bus_tag_q[$];

  always #5 clk = ~clk;

  cfgx_port_xlat #(.NUM_DEV(ND), .IO_AW(16)) dut (.*);

  task automatic check(input bit ok, input string tag, input logic [77:0] act, input logic [77:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cycle(input logic [31:0] a, input logic t1, input logic [ND-1:0] ids,
                              input logic [3:0] be, input logic wr, input logic [31:0] wd,
                              input logic ab, input logic [31:0] rd, input string tag);
    bus_exp_q.push_back({a, t1, ids, be, wr, wd});
    bus_rep_q.push_back({ab, rd});
    bus_tag_q.push_back(tag);
  endtask

  task automatic io_access(input logic wr, input logic [15:0] port, input logic [3:0] be,
                           input logic [31:0] wd, input logic [31:0] exp, input string tag);
    logic rdy;
    rsp_exp_q.push_back(exp);
    rsp_tag_q.push_back(tag);
    @(negedge clk);
    io_req_valid = 1; io_req_write = wr; io_req_port = port;
    io_req_be = be; io_req_wdata = wd;
    do begin
      rdy = io_req_ready;
      @(posedge clk);
    end while (!rdy);
    #1 io_req_valid = 0;
  endtask

  task automatic drain;
    while (rsp_exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Response monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      io_rsp_ready = stall_en ? (cyc % 4 == 3) : 1'b1;
      if (io_rsp_valid) begin
        // R9: no new request accepted while a response is pending
        if (!io_rsp_ready) check(io_req_ready == 0, "R9 ready while pending", 78'(io_req_ready), 78'(0));
        else if (rsp_exp_q.size() == 0) check(0, "R9 unexpected response", 78'(io_rsp_rdata), 78'(0));
        else begin
          logic [31:0] e;
          string t;
          e = rsp_exp_q.pop_front();
          t = rsp_tag_q.pop_front();
          check(io_rsp_rdata == e, t, 78'(io_rsp_rdata), 78'(e));
        end
      end
    end
  end

  // Target model
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_valid) begin
        logic [77:0] got;
        got = {cfg_addr, cfg_type1, cfg_idsel, cfg_be, cfg_write, cfg_wdata};
        txn_count++;
        if (bus_exp_q.size() == 0) begin
          check(0, "R8 unexpected transaction", got, 78'(0));
          cfg_done = 1;
        end else begin
          logic [77:0] e;
          logic [32:0] rep;
          string t;
          e = bus_exp_q.pop_front();
          rep = bus_rep_q.pop_front();
          t = bus_tag_q.pop_front();
          check(got == e, t, got, e);
          repeat (2) @(negedge clk);
          check(cfg_valid && cfg_addr == e[77:46], "R8 held", 78'(cfg_addr), 78'(e[77:46]));
          cfg_abort = rep[32]; cfg_done = !rep[32]; cfg_rdata = rep[31:0];
        end
        @(negedge clk);
        cfg_done = 0; cfg_abort = 0; cfg_rdata = 0;
        check(cfg_valid == 0, "R8 drop after completion", 78'(cfg_valid), 78'(0));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(io_req_ready == 1 && io_rsp_valid == 0 && cfg_valid == 0, "R10 reset outputs",
          78'({io_req_ready, io_rsp_valid, cfg_valid}), 78'(3'b100));
    io_access(0, 16'h0CF8, 4'hF, 0, 32'h0, "R10 selector after reset");

    // Disabled window
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hFFFF_FFFF, "R2 disabled read");
    io_access(1, 16'h0CFC, 4'hF, 32'h1234, 32'h0, "R2 disabled write");
    drain();
    check(txn_count == 0, "R2 no transaction", 78'(txn_count), 78'(0));

    // Selector layout: reserved and low bits read zero
    io_access(1, 16'h0CF8, 4'hF, 32'hFF00_1A13, 32'h0, "R1 write");
    io_access(0, 16'h0CF8, 4'hF, 0, 32'h8000_1A10, "R1 readback");

    // Type 0, device 3, function 2, register 0x10
    expect_cycle(32'h0000_0210, 0, 8'h08, 4'hF, 0, 0, 0, 32'hCAFE_BABE, "R4 type0 read");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hCAFE_BABE, "R7 done read");
    expect_cycle(32'h0000_0210, 0, 8'h08, 4'b1100, 1, 32'hA5A5_0000, 0, 0, "R6 upper word write");
    io_access(1, 16'h0CFE, 4'b1100, 32'hA5A5_0000, 32'h0, "R7 write response");

    // Abort and back-pressure
    stall_en = 1;
    expect_cycle(32'h0000_0210, 0, 8'h08, 4'hF, 0, 0, 1, 32'h1234_5678, "R4 abort cycle");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hFFFF_FFFF, "R7 abort read");
    expect_cycle(32'h0000_0210, 0, 8'h08, 4'b0011, 0, 0, 0, 32'h1122_3344, "R6 byte enables");
    io_access(0, 16'h0CFC, 4'b0011, 0, 32'h1122_3344, "R9 stalled read");
    drain();
    stall_en = 0;

    // Type 1: bus 5, device 17, function 1, register 0x3C
    io_access(1, 16'h0CF8, 4'hF, 32'h8005_893C, 32'h0, "R1 write type1 target");
    expect_cycle(32'h0005_893D, 1, 8'h00, 4'hF, 0, 0, 0, 32'h7654_3210, "R5 type1 read");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'h7654_3210, "R5 read data");
    expect_cycle(32'h0005_893D, 1, 8'h00, 4'b0001, 1, 32'h0000_0099, 0, 0, "R5 type1 write");
    io_access(1, 16'h0CFC, 4'b0001, 32'h0000_0099, 32'h0, "R6 write response");
    drain();

    // Same target now local; device 17 has no select line
    local_bus = 8'd5;
    expect_cycle(32'h0000_013C, 0, 8'h00, 4'hF, 0, 0, 1, 0, "R4 unwired device");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hFFFF_FFFF, "R7 abort unwired");

    // Partial selector write
    io_access(1, 16'h0CF8, 4'b0100, 32'h0009_0000, 32'h0, "R1 lane write");
    io_access(0, 16'h0CF8, 4'hF, 0, 32'h8009_893C, "R1 lane readback");

    // Foreign ports
    drain();
    base = txn_count;
    io_access(1, 16'h0CF4, 4'hF, 32'hFFFF_FFFF, 32'h0, "R3 foreign write");
    io_access(0, 16'h0CF4, 4'hF, 0, 32'hFFFF_FFFF, "R3 foreign read");
    io_access(0, 16'h0D00, 4'hF, 0, 32'hFFFF_FFFF, "R3 foreign read high");
    io_access(0, 16'h0CF8, 4'hF, 0, 32'h8009_893C, "R3 selector untouched");
    drain();
    check(txn_count == base, "R3 no transaction", 78'(txn_count), 78'(base));

    // Clear enable through lane 3
    io_access(1, 16'h0CF8, 4'b1000, 32'h0, 32'h0, "R1 clear enable");
    io_access(0, 16'h0CF8, 4'hF, 0, 32'h0009_893C, "R1 enable cleared");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hFFFF_FFFF, "R2 read after clear");
    io_access(1, 16'h0CFC, 4'hF, 32'h55, 32'h0, "R2 write after clear");
    drain();
    check(txn_count == base, "R2 no transaction after clear", 78'(txn_count), 78'(base));

    // Highest wired select lane: bus 5, device 7
    io_access(1, 16'h0CF8, 4'hF, 32'h8005_3800, 32'h0, "R1 write device 7");
    expect_cycle(32'h0000_0000, 0, 8'h80, 4'hF, 0, 0, 0, 32'hDEAD_0007, "R4 top lane");
    io_access(0, 16'h0CFC, 4'hF, 0, 32'hDEAD_0007, "R7 top lane data");
    drain();

    check(bus_exp_q.size() == 0, "R8 all expected transactions seen", 78'(bus_exp_q.size()), 78'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule